// File: doc/BRIEF.md
# Synchronized Clock-Stop Gate for Two Output Groups

This block gates two groups of clock outputs, a three-output processor group and a seven-output bus group, all copied from one internal source clock. Each group has its own active-low stop pin that may change at any time relative to the clock. The pin is brought into the clock domain through a two-flop synchronizer before use. A software stop bit can replace the pin as the stop source, chosen by a per-group select bit.

Each output has a stoppable bit. An output whose bit is clear keeps running whatever the stop request does. A stoppable output stops in the low state and restarts with a full-width high phase, because every output enable is re-timed on the falling edge of the source clock. A small sequencer per group counts the off latency, the on latency and a minimum enabled window. A stop request that arrives inside that window waits until the window has run out.

Configuration (select, software stop and stoppable bits for both groups) is held in a register loaded from the `cfg_*` inputs on a rising edge with `cfg_wr_i` high.

Top module: `clkstop_gate`

## Requirements
- R1: A stop pin is sampled by two flops on rising edges and acts only when its group's select bit is 1 (select 1 = pin, 0 = software bit). With select 0 the pin has no effect on the outputs. A pin change between edges p0 and p1 is acted on at edge p3.
- R2: A stopped output is held low, and every high phase of every output spans the whole high half of the source clock: no shortened pulse, and never high while the source clock is low.
- R3: Off latency: when a request is acted on at edge e, a stoppable output still pulses on edges e to e+OFF_LAT and not after. After a pin falls between edges, the bus group gives 4 more pulses (OFF_LAT 1) and the processor group gives 6 (OFF_LAT 3).
- R4: An output whose stoppable bit is 0 is never stopped. Clearing the bit of a stopped output makes it pulse from the second rising edge after the write.
- R5: Every enabled burst of a stoppable output has at least MIN_ON pulses (10 for the bus group, 100 for the processor group). A request held from the start of a burst ends it after exactly MIN_ON pulses.
- R6: On latency: after the pin rises between edges p0 and p1, the first pulse is on edge p(4+ON_LAT). This is edge 6 for the bus group (ON_LAT 2) and edge 7 for the processor group (ON_LAT 3).
- R7: After reset all ten outputs run. Both select bits are 1 and both software bits are 0. Processor stoppable bits are 3'b110: bit 0 is free-running, bits 1 and 2 are stoppable. Bus stoppable bits are 7'b1110000: bits 0 to 3 are free-running, bits 4 to 6 are stoppable.
- R8: Configuration is captured on the rising edge where `cfg_wr_i` is 1. A software stop written at edge p0 passes through the same two flops as the pin, so the bus group gives 5 pulses counted from p0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_stop_ni | input | 1 | Asynchronous active-low stop pin, processor group |
| pci_stop_ni | input | 1 | Asynchronous active-low stop pin, bus group |
| cfg_wr_i | input | 1 | Load strobe for the configuration register |
| cfg_cpu_hw_sel_i | input | 1 | Processor stop source: 1 pin, 0 software bit |
| cfg_cpu_sw_stop_i | input | 1 | Processor software stop bit |
| cfg_cpu_stoppable_i | input | 3 | Processor stoppable bits, 1 = stoppable |
| cfg_pci_hw_sel_i | input | 1 | Bus stop source: 1 pin, 0 software bit |
| cfg_pci_sw_stop_i | input | 1 | Bus software stop bit |
| cfg_pci_stoppable_i | input | 7 | Bus stoppable bits, 1 = stoppable |
| cpu_clk_o | output | 3 | Gated processor clock outputs |
| pci_clk_o | output | 7 | Gated bus clock outputs |

## Verification
The assertions assume that the source clock runs without pause and that the latency parameters stay small, since their depth sets the look-back of the latency checks. They also assume that the stoppable bits change only through the configuration register, so that they are stable between rising edges. The stimulus changes pins and configuration only at falling edges. It measures pulses by sampling each output several times inside each high phase and once inside each low phase. Every pin change is held long enough for the synchronizer and the sequencer to finish their latency before the next change.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_GO_OFF = 2'd1,
    ST_OFF    = 2'd2,
    ST_GO_ON  = 2'd3
  } gate_state_e;

  // Value of the run counter at which a pending stop may be taken, so that
  // the burst including the off-latency pulses holds min_on pulses.
  function automatic int run_threshold(int min_on, int off_lat);
    return min_on - off_lat - 1;
  endfunction

  function automatic int lat_width(int off_lat, int on_lat);
    return $clog2(((off_lat > on_lat) ? off_lat : on_lat) + 1);
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/clkstop_seq.sv
module clkstop_seq
  import clkstop_pkg::*;
#(
  parameter int OFF_LAT = 1,
  parameter int ON_LAT  = 2,
  parameter int MIN_ON  = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic gate_on_o
);
  localparam int RUN_W = $clog2(MIN_ON + 1);
  localparam int LAT_W = lat_width(OFF_LAT, ON_LAT);
  localparam logic [RUN_W-1:0] RUN_THR = RUN_W'(run_threshold(MIN_ON, OFF_LAT));
  localparam logic [LAT_W-1:0] OFF_TOP = LAT_W'(OFF_LAT - 1);
  localparam logic [LAT_W-1:0] ON_TOP  = LAT_W'(ON_LAT - 1);

  gate_state_e       st_q;
  logic [RUN_W-1:0]  run_cnt_q;
  logic [LAT_W-1:0]  lat_cnt_q;
  logic              window_done;

  assign window_done = (run_cnt_q == RUN_THR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_RUN;
      run_cnt_q <= '0;
      lat_cnt_q <= '0;
    end else begin
      case (st_q)
        ST_RUN: begin
          if (!window_done) run_cnt_q <= run_cnt_q + 1'b1;
          if (req_i && window_done) begin
            st_q      <= ST_GO_OFF;
            lat_cnt_q <= '0;
          end
        end
        ST_GO_OFF: begin
          if (lat_cnt_q == OFF_TOP) st_q <= ST_OFF;
          else lat_cnt_q <= lat_cnt_q + 1'b1;
        end
        ST_OFF: begin
          if (!req_i) begin
            st_q      <= ST_GO_ON;
            lat_cnt_q <= '0;
          end
        end
        default: begin
          if (lat_cnt_q == ON_TOP) begin
            st_q      <= ST_RUN;
            run_cnt_q <= '0;
          end else begin
            lat_cnt_q <= lat_cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign gate_on_o = (st_q == ST_RUN) || (st_q == ST_GO_OFF);
endmodule

// File: rtl/clkstop_outgate.sv
module clkstop_outgate #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         gate_on_i,
  input  logic [N-1:0] stoppable_i,
  output logic         run_o,
  output logic [N-1:0] clk_o
);
  logic [N-1:0] en_q;
  logic         run_q;

  // Enables move only on the falling edge, while the source clock is low.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '1;
      run_q <= 1'b1;
    end else begin
      en_q  <= {N{gate_on_i}} | ~stoppable_i;
      run_q <= gate_on_i;
    end
  end

  assign run_o = run_q;

  for (genvar i = 0; i < N; i++) begin : g_out
    assign clk_o[i] = clk_i & en_q[i];

    // R4: a free-running output keeps its enable
    a_r4_free_output_runs : assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      !stoppable_i[i] |-> en_q[i]
    );
  end
endmodule

// File: rtl/clkstop_group.sv
module clkstop_group #(
  parameter int N       = 3,
  parameter int OFF_LAT = 1,
  parameter int ON_LAT  = 2,
  parameter int MIN_ON  = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stop_ni,
  input  logic         hw_sel_i,
  input  logic         sw_stop_i,
  input  logic [N-1:0] stoppable_i,
  output logic [N-1:0] clk_o
);
  localparam int BURST_W = $clog2(MIN_ON + 1);

  logic [1:0] req_raw, req_sync;
  logic       eff_req;
  logic       gate_on;
  logic       run_q;

  // Software bit rides the same two flops so both sources share one latency.
  assign req_raw = {sw_stop_i, ~stop_ni};

  clkstop_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_raw),
    .q_o   (req_sync)
  );

  assign eff_req = hw_sel_i ? req_sync[0] : req_sync[1];

  clkstop_seq #(
    .OFF_LAT(OFF_LAT),
    .ON_LAT (ON_LAT),
    .MIN_ON (MIN_ON)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (eff_req),
    .gate_on_o(gate_on)
  );

  clkstop_outgate #(.N(N)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gate_on_i  (gate_on),
    .stoppable_i(stoppable_i),
    .run_o      (run_q),
    .clk_o      (clk_o)
  );

  // Checker state: length of the current enabled burst in rising edges.
  logic [BURST_W-1:0] burst_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) burst_len_q <= '0;
    else if (!run_q) burst_len_q <= '0;
    else if (burst_len_q != BURST_W'(MIN_ON)) burst_len_q <= burst_len_q + 1'b1;
  end

  // R5: a burst never ends before MIN_ON pulses
  a_r5_min_burst : assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> (burst_len_q == BURST_W'(MIN_ON))
  );

  // R3: the stop seen at the outputs was requested OFF_LAT+1 edges earlier
  a_r3_stop_follows_request : assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> $past(eff_req, OFF_LAT + 1)
  );

  // R6: the restart seen at the outputs was released ON_LAT+1 edges earlier
  a_r6_restart_follows_release : assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> !$past(eff_req, ON_LAT + 1)
  );
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int CPU_N       = 3,
  parameter int PCI_N       = 7,
  parameter int CPU_OFF_LAT = 3,
  parameter int CPU_ON_LAT  = 3,
  parameter int CPU_MIN_ON  = 100,
  parameter int PCI_OFF_LAT = 1,
  parameter int PCI_ON_LAT  = 2,
  parameter int PCI_MIN_ON  = 10,
  parameter logic [CPU_N-1:0] CPU_STOPPABLE_RST = 3'b110,
  parameter logic [PCI_N-1:0] PCI_STOPPABLE_RST = 7'b1110000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_stop_ni,
  input  logic             pci_stop_ni,
  input  logic             cfg_wr_i,
  input  logic             cfg_cpu_hw_sel_i,
  input  logic             cfg_cpu_sw_stop_i,
  input  logic [CPU_N-1:0] cfg_cpu_stoppable_i,
  input  logic             cfg_pci_hw_sel_i,
  input  logic             cfg_pci_sw_stop_i,
  input  logic [PCI_N-1:0] cfg_pci_stoppable_i,
  output logic [CPU_N-1:0] cpu_clk_o,
  output logic [PCI_N-1:0] pci_clk_o
);
  logic             cpu_hw_sel_q, cpu_sw_stop_q;
  logic             pci_hw_sel_q, pci_sw_stop_q;
  logic [CPU_N-1:0] cpu_stoppable_q;
  logic [PCI_N-1:0] pci_stoppable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_hw_sel_q    <= 1'b1;
      cpu_sw_stop_q   <= 1'b0;
      cpu_stoppable_q <= CPU_STOPPABLE_RST;
      pci_hw_sel_q    <= 1'b1;
      pci_sw_stop_q   <= 1'b0;
      pci_stoppable_q <= PCI_STOPPABLE_RST;
    end else if (cfg_wr_i) begin
      cpu_hw_sel_q    <= cfg_cpu_hw_sel_i;
      cpu_sw_stop_q   <= cfg_cpu_sw_stop_i;
      cpu_stoppable_q <= cfg_cpu_stoppable_i;
      pci_hw_sel_q    <= cfg_pci_hw_sel_i;
      pci_sw_stop_q   <= cfg_pci_sw_stop_i;
      pci_stoppable_q <= cfg_pci_stoppable_i;
    end
  end

  clkstop_group #(
    .N      (CPU_N),
    .OFF_LAT(CPU_OFF_LAT),
    .ON_LAT (CPU_ON_LAT),
    .MIN_ON (CPU_MIN_ON)
  ) u_cpu (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_ni    (cpu_stop_ni),
    .hw_sel_i   (cpu_hw_sel_q),
    .sw_stop_i  (cpu_sw_stop_q),
    .stoppable_i(cpu_stoppable_q),
    .clk_o      (cpu_clk_o)
  );

  clkstop_group #(
    .N      (PCI_N),
    .OFF_LAT(PCI_OFF_LAT),
    .ON_LAT (PCI_ON_LAT),
    .MIN_ON (PCI_MIN_ON)
  ) u_pci (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_ni    (pci_stop_ni),
    .hw_sel_i   (pci_hw_sel_q),
    .sw_stop_i  (pci_sw_stop_q),
    .stoppable_i(pci_stoppable_q),
    .clk_o      (pci_clk_o)
  );
endmodule

// File: tb/clkstop_gate_tb.sv
`timescale 1ns/1ps
module clkstop_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cp = 1'b1, pp = 1'b1;
  logic       cfg_wr = 1'b0;
  logic       c_hw = 1'b1, c_sw = 1'b0, p_hw = 1'b1, p_sw = 1'b0;
  logic [2:0] c_mask = 3'b110;
  logic [6:0] p_mask = 7'b1110000;
  logic [2:0] cpu_clk;
  logic [6:0] pci_clk;

  int checks = 0, fails = 0;
  int cnt[10];
  int runts = 0, lowhigh = 0;
  logic [9:0] allc, sa, sm, sb;

  always #2.5 clk = ~clk;

  clkstop_gate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cpu_stop_ni(cp), .pci_stop_ni(pp),
    .cfg_wr_i(cfg_wr), .cfg_cpu_hw_sel_i(c_hw), .cfg_cpu_sw_stop_i(c_sw),
    .cfg_cpu_stoppable_i(c_mask), .cfg_pci_hw_sel_i(p_hw),
    .cfg_pci_sw_stop_i(p_sw), .cfg_pci_stoppable_i(p_mask),
    .cpu_clk_o(cpu_clk), .pci_clk_o(pci_clk)
  );

  assign allc = {pci_clk, cpu_clk};

  // Index 0..2 = processor outputs, 3..9 = bus outputs 0..6.
  always @(posedge clk) begin
    #0.3 sa = allc;
    #0.7 sm = allc;
    for (int i = 0; i < 10; i++) if (sm[i]) cnt[i]++;
    #1.2 sb = allc;
    if (rst_n && (sa != sm || sm != sb)) runts++;
    #1.3 if (allc != 10'd0) lowhigh++;
  end

  task automatic clr();
    for (int i = 0; i < 10; i++) cnt[i] = 0;
  endtask

  task automatic run(int k);
    repeat (k) begin
      @(negedge clk);
      cfg_wr = 1'b0;
    end
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wcfg(logic phw, logic psw, logic [6:0] pm);
    c_hw = 1'b1; c_sw = 1'b0; c_mask = 3'b110;
    p_hw = phw; p_sw = psw; p_mask = pm;
    cfg_wr = 1'b1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    clr();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    clr();
    run(5);
    // R7: every output runs after reset
    for (int i = 0; i < 10; i++) check("R7", $sformatf("reset run out%0d", i), cnt[i], 5);
    run(120);

    // R3 bus group stop via pin, R4/R7 free-running bus outputs 0..3
    pp = 1'b0; clr(); run(30);
    check("R3", "bus out4 off latency", cnt[7], 4);
    check("R3", "bus out6 off latency", cnt[9], 4);
    check("R4", "bus out0 free", cnt[3], 30);
    check("R7", "bus out3 free by reset mask", cnt[6], 30);
    check("R3", "cpu untouched", cnt[1], 30);
    clr(); run(20);
    check("R2", "bus out5 held low", cnt[8], 0);

    // R6 bus restart, then R5 minimum burst
    pp = 1'b1; clr(); run(5);
    check("R6", "bus no pulse before edge 6", cnt[7], 0);
    run(1);
    check("R6", "bus first pulse on edge 6", cnt[7], 1);
    pp = 1'b0; run(40);
    check("R5", "bus burst length", cnt[7], 10);
    pp = 1'b1; run(40);

    // R3 processor group stop, R4 processor free output
    cp = 1'b0; clr(); run(30);
    check("R3", "cpu out1 off latency", cnt[1], 6);
    check("R3", "cpu out2 off latency", cnt[2], 6);
    check("R4", "cpu out0 free", cnt[0], 30);
    check("R3", "bus untouched", cnt[8], 30);
    cp = 1'b1; clr(); run(6);
    check("R6", "cpu no pulse before edge 7", cnt[1], 0);
    run(1);
    check("R6", "cpu first pulse on edge 7", cnt[1], 1);
    cp = 1'b0; run(150);
    check("R5", "cpu burst length", cnt[1], 100);
    cp = 1'b1; run(20);

    // R1 pin ignored with software select, R8 software stop
    wcfg(1'b0, 1'b0, 7'b1110000); run(10);
    pp = 1'b0; clr(); run(30);
    check("R1", "bus pin ignored in software mode", cnt[8], 30);
    wcfg(1'b0, 1'b1, 7'b1110000); clr(); run(30);
    check("R8", "bus software stop latency", cnt[8], 5);
    check("R8", "bus free out0 under software stop", cnt[3], 30);
    wcfg(1'b0, 1'b1, 7'b0000000); clr(); run(20);
    check("R4", "cleared stoppable bit restarts out5", cnt[8], 19);
    wcfg(1'b1, 1'b0, 7'b1110000); pp = 1'b1; run(20);

    check("R2", "shortened pulses", runts, 0);
    check("R2", "high during low phase", lowhigh, 0);
    summary();
    $finish;
  end
endmodule